// File: doc/BRIEF.md
# Faulty-Device Slice Coalescer

This block sits in the read and write data path of a memory controller that talks to a 72-bit ECC channel built from eighteen x4 devices. When one device has a permanent fault, only that device's share of each codeword needs a new home. The coalescer takes each codeword, which arrives as a burst of eight 72-bit beats, and cuts out the faulty device's nibble from every beat. It joins those eight nibbles into a 32-bit slice and files the slice into one of sixteen slots of a 64-byte line. When all sixteen slots hold data, the line is flagged full so the cache can lock it.

A lookup table holds one precomputed lane mask per device and drives both the extraction and the merge. When a read hits a slot that already holds data, the coalescer puts the stored slice back into the outgoing codeword in place of the faulty nibbles. A write replaces the stored slice with the new one. The slot is picked by the low four bits of the codeword's column address. The bits of every other device pass through unchanged, one register stage later. A start pulse empties the line before the next set of sixteen codewords is gathered.

Top module: `rfc_coalescer`

## Requirements
- R1: After reset, slot_valid is all zeros, line_full is 0 and out_valid is 0.
- R2: Each beat accepted with beat_valid=1 appears on out_data with out_valid=1 exactly one cycle later. For every device other than the faulty one, the nibble at bits [4d+3:4d] of out_data equals the input beat.
- R3: fault_dev=d (0..17) selects the nibble at bits [4d+3:4d] of every beat, taking effect one cycle after fault_dev changes. A value of 18 or more selects no bits: every codeword passes unchanged and the captured slices are zero.
- R4: A codeword is a burst of 8 consecutive accepted beats. The nibble of beat b (b=0..7) goes to slice bits [4b+3:4b]. The slot s is beat_col[3:0] taken at beat 0. The slice is held in line_data bits [32s+31:32s].
- R5: A read burst (beat_write=0) to an empty slot passes the codeword unchanged. It stores the slice and sets slot_valid[s], visible in the cycle after the last beat.
- R6: In a read burst to a filled slot, the faulty nibble of output beat b is replaced by bits [4b+3:4b] of the stored slice, and the stored slice is left unchanged.
- R7: A write burst (beat_write=1) passes the codeword unchanged and overwrites slot s with the new slice. All other slots keep their contents.
- R8: line_full is 1 exactly when all 16 bits of slot_valid are 1. It updates in the same cycle as slot_valid.
- R9: A line_start pulse clears slot_valid and line_full in the next cycle. If a write burst ends in the same cycle as the pulse, only that burst's slot is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_dev | input | 5 | Index of the faulty device |
| line_start | input | 1 | Empty the line and begin a new one |
| beat_valid | input | 1 | A codeword beat is present |
| beat_write | input | 1 | 1 = write burst, 0 = read burst |
| beat_col | input | 10 | Column address of the codeword; bits [3:0] pick the slot |
| beat_data | input | 72 | Codeword beat |
| out_valid | output | 1 | Outgoing beat present |
| out_data | output | 72 | Outgoing beat, with the merge applied on read hits |
| line_data | output | 512 | Packed line; slot s at bits [32s+31:32s] |
| slot_valid | output | 16 | Slot-holds-data mask |
| line_full | output | 1 | All slots filled; the line may be locked |

## Verification
Every device index from 0 to 17, plus the out-of-range index 18, is swept. For each one, sixteen random codewords are read with the slots taken in a shuffled order. This separates a wrong lane pick or a wrong beat-to-bit order from a wrong slot decode, and the shuffle shows that line_full depends on the count of filled slots rather than their order. The same line is then re-read with fresh random data, which separates substitution on a hit from plain pass-through. A single overwriting write separates a slot update from a disturbance of its neighbours. Finally, a write whose last beat meets a line_start pulse checks that the clear and the store combine as stated.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int RFC_NUM_DEV = 18;
  localparam int RFC_DEV_W   = 4;
  localparam int RFC_BEATS   = 8;
  localparam int RFC_SLOTS   = 16;
  localparam int RFC_COL_W   = 10;
  localparam int RFC_ID_W    = 5;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } rfc_op_e;
endpackage

// File: rtl/rfc_mask_rom.sv
module rfc_mask_rom #(
  parameter int NUM_DEV = 18,
  parameter int DEV_W   = 4,
  parameter int ID_W    = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ID_W-1:0]          dev_id,
  output logic [NUM_DEV*DEV_W-1:0] mask_q
);
  localparam int W = NUM_DEV * DEV_W;
  localparam logic [ID_W-1:0] NUM_ID = ID_W'(NUM_DEV);

  logic [W-1:0] rom [NUM_DEV];

  // one lane mask per device, computed at elaboration
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_rom
    assign rom[d] = {{(W-DEV_W){1'b0}}, {DEV_W{1'b1}}} << (d * DEV_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (dev_id < NUM_ID) begin
      mask_q <= rom[dev_id];
    end else begin
      mask_q <= '0;
    end
  end

  // R3: a non-empty mask only follows an in-range device index
  p_mask_range_r3: assert property (@(posedge clk) disable iff (rst)
    (mask_q != '0) |-> ($past(dev_id) < NUM_ID));

  // R3: a mask never covers more than one device lane
  p_mask_width_r3: assert property (@(posedge clk) disable iff (rst)
    ($countones(mask_q) == 0) || ($countones(mask_q) == DEV_W));
endmodule

// File: rtl/rfc_slice_path.sv
module rfc_slice_path #(
  parameter int NUM_DEV = 18,
  parameter int DEV_W   = 4
) (
  input  logic [NUM_DEV*DEV_W-1:0] beat,
  input  logic [NUM_DEV*DEV_W-1:0] mask,
  input  logic                     subst_en,
  input  logic [DEV_W-1:0]         subst_nib,
  output logic [DEV_W-1:0]         nib,
  output logic [NUM_DEV*DEV_W-1:0] merged
);
  localparam int W = NUM_DEV * DEV_W;

  logic [W-1:0] masked;

  assign masked = beat & mask;

  // fold all lanes: only the selected one can be non-zero
  always_comb begin
    nib = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      nib = nib | masked[d*DEV_W +: DEV_W];
    end
  end

  always_comb begin
    if (subst_en) begin
      merged = (beat & ~mask) | ({NUM_DEV{subst_nib}} & mask);
    end else begin
      merged = beat;
    end
  end
endmodule

// File: rtl/rfc_line_store.sv
module rfc_line_store #(
  parameter int SLOTS   = 16,
  parameter int SLICE_W = 32,
  parameter int SLOT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     wr_en,
  input  logic [SLOT_W-1:0]        wr_slot,
  input  logic [SLICE_W-1:0]       wr_data,
  input  logic [SLOT_W-1:0]        rd_slot,
  output logic [SLICE_W-1:0]       rd_data,
  output logic                     rd_valid,
  output logic [SLOTS*SLICE_W-1:0] line_q,
  output logic [SLOTS-1:0]         valid_q,
  output logic                     full_q
);
  logic [SLICE_W-1:0] mem [SLOTS];
  logic [SLOTS-1:0]   valid_nxt;
  logic [SLOTS-1:0]   wr_onehot;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_slot] <= wr_data;
    end
  end

  assign rd_data  = mem[rd_slot];
  assign rd_valid = valid_q[rd_slot];

  for (genvar i = 0; i < SLOTS; i++) begin : g_flat
    assign line_q[i*SLICE_W +: SLICE_W] = mem[i];
  end

  assign wr_onehot = wr_en ? (SLOTS'(1) << wr_slot) : '0;
  assign valid_nxt = (clear ? '0 : valid_q) | wr_onehot;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      full_q  <= 1'b0;
    end else begin
      valid_q <= valid_nxt;
      full_q  <= &valid_nxt;
    end
  end

  // R9: the mask does not move without a store or a clear
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!clear && !wr_en) |=> (valid_q == $past(valid_q)));

  // R9: a clear with no store leaves the mask empty
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clear && !wr_en) |=> (valid_q == '0) && !full_q);

  // R8: the line only becomes full on a store
  p_full_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> $past(wr_en));

  // R5: a store always leaves its slot marked
  p_store_marks_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_slot)]);
endmodule

// File: rtl/rfc_coalescer.sv
module rfc_coalescer
  import rfc_pkg::*;
#(
  parameter int NUM_DEV = RFC_NUM_DEV,
  parameter int DEV_W   = RFC_DEV_W,
  parameter int BEATS   = RFC_BEATS,
  parameter int SLOTS   = RFC_SLOTS,
  parameter int COL_W   = RFC_COL_W,
  parameter int ID_W    = RFC_ID_W,
  localparam int DATA_W  = NUM_DEV * DEV_W,
  localparam int SLICE_W = DEV_W * BEATS,
  localparam int LINE_W  = SLOTS * SLICE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   fault_dev,
  input  logic              line_start,
  input  logic              beat_valid,
  input  logic              beat_write,
  input  logic [COL_W-1:0]  beat_col,
  input  logic [DATA_W-1:0] beat_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [LINE_W-1:0] line_data,
  output logic [SLOTS-1:0]  slot_valid,
  output logic              line_full
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(BEATS);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic [DATA_W-1:0]  mask_q;
  logic [CNT_W-1:0]   cnt;
  logic [SLOT_W-1:0]  col_q;
  logic [SLOT_W-1:0]  slot;
  logic [SLICE_W-1:0] acc;
  logic [SLICE_W-1:0] slice_w;
  logic [SLICE_W-1:0] stored;
  logic               stored_vld;
  logic [DEV_W-1:0]   nib;
  logic [DEV_W-1:0]   subst_nib;
  logic               subst_en;
  logic               last;
  logic               st_en;
  logic [DATA_W-1:0]  merged;
  rfc_op_e            op;

  assign op   = rfc_op_e'(beat_write);
  assign last = (cnt == LAST_BEAT);
  assign slot = (cnt == '0) ? beat_col[SLOT_W-1:0] : col_q;

  rfc_mask_rom #(
    .NUM_DEV (NUM_DEV),
    .DEV_W   (DEV_W),
    .ID_W    (ID_W)
  ) u_rom (
    .clk    (clk),
    .rst    (rst),
    .dev_id (fault_dev),
    .mask_q (mask_q)
  );

  assign subst_nib = stored[cnt*DEV_W +: DEV_W];
  assign subst_en  = beat_valid && (op == OP_READ) && stored_vld;

  rfc_slice_path #(
    .NUM_DEV (NUM_DEV),
    .DEV_W   (DEV_W)
  ) u_path (
    .beat      (beat_data),
    .mask      (mask_q),
    .subst_en  (subst_en),
    .subst_nib (subst_nib),
    .nib       (nib),
    .merged    (merged)
  );

  // slice as it stands at the final beat
  always_comb begin
    slice_w = acc;
    slice_w[(BEATS-1)*DEV_W +: DEV_W] = nib;
  end

  assign st_en = beat_valid && last && ((op == OP_WRITE) || !stored_vld);

  rfc_line_store #(
    .SLOTS   (SLOTS),
    .SLICE_W (SLICE_W),
    .SLOT_W  (SLOT_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .clear    (line_start),
    .wr_en    (st_en),
    .wr_slot  (slot),
    .wr_data  (slice_w),
    .rd_slot  (slot),
    .rd_data  (stored),
    .rd_valid (stored_vld),
    .line_q   (line_data),
    .valid_q  (slot_valid),
    .full_q   (line_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      col_q <= '0;
      acc   <= '0;
    end else if (beat_valid) begin
      acc[cnt*DEV_W +: DEV_W] <= nib;
      if (cnt == '0) begin
        col_q <= beat_col[SLOT_W-1:0];
      end
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= beat_valid;
      out_data  <= merged;
    end
  end

  // R2: lanes outside the selected device are copied from the input beat
  p_pass_lanes_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (((out_data ^ $past(beat_data)) & ~$past(mask_q)) == '0));

  // R2: every accepted beat is presented one cycle later
  p_beat_out_r2: assert property (@(posedge clk) disable iff (rst)
    beat_valid |=> out_valid);

  // R4: the beat counter returns to zero after the final beat
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && last) |=> (cnt == '0));

  // R4: the counter holds when no beat arrives
  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !beat_valid |=> $stable(cnt));
endmodule

// File: tb/rfc_coalescer_tb.sv
module rfc_coalescer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV  = 18;
  localparam int DW    = 72;
  localparam int NSLOT = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [4:0]   fault_dev;
  logic         line_start;
  logic         beat_valid;
  logic         beat_write;
  logic [9:0]   beat_col;
  logic [71:0]  beat_data;
  logic         out_valid;
  logic [71:0]  out_data;
  logic [511:0] line_data;
  logic [15:0]  slot_valid;
  logic         line_full;

  int n_vec  = 0;
  int n_fail = 0;
  int dev    = 0;
  bit done   = 1'b0;

  logic [31:0] m_line [NSLOT];
  logic [15:0] m_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfc_coalescer u_dut (
    .clk        (clk),
    .rst        (rst),
    .fault_dev  (fault_dev),
    .line_start (line_start),
    .beat_valid (beat_valid),
    .beat_write (beat_write),
    .beat_col   (beat_col),
    .beat_data  (beat_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .line_data  (line_data),
    .slot_valid (slot_valid),
    .line_full  (line_full)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_of(input logic [71:0] b, input int d);
    if (d < NDEV) return b[d*4 +: 4];
    return 4'h0;
  endfunction

  function automatic logic [71:0] put_nib(input logic [71:0] b, input int d,
                                          input logic [3:0] n);
    logic [71:0] r;
    r = b;
    if (d < NDEV) r[d*4 +: 4] = n;
    return r;
  endfunction

  function automatic logic [71:0] rnd72();
    return {8'($urandom), $urandom, $urandom};
  endfunction

  task automatic check_mask(input string req);
    chk(slot_valid == m_valid, req, 512'(slot_valid), 512'(m_valid));
    chk(line_full == (&m_valid), "R8", 512'(line_full), 512'(&m_valid));
  endtask

  task automatic check_line(input string req);
    for (int s = 0; s < NSLOT; s++) begin
      if (m_valid[s])
        chk(line_data[s*32 +: 32] == m_line[s], req,
            512'(line_data[s*32 +: 32]), 512'(m_line[s]));
    end
  endtask

  // one 8-beat codeword; clr_last raises line_start with the final beat
  task automatic run_burst(input logic [3:0] slot, input bit wr, input bit clr_last);
    logic [71:0] d   [8];
    logic [71:0] exp [8];
    logic [31:0] slice;
    bit          hit;
    string       tag;
    hit = m_valid[slot] && !wr;
    tag = (dev >= NDEV) ? "R3" : (wr ? "R7" : (hit ? "R6" : "R5"));
    for (int b = 0; b < 8; b++) begin
      d[b] = rnd72();
      exp[b] = hit ? put_nib(d[b], dev, m_line[slot][b*4 +: 4]) : d[b];
      slice[b*4 +: 4] = nib_of(d[b], dev);
    end
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      if (b > 0) begin
        chk(out_valid, "R2", 512'(out_valid), 512'(1));
        chk(out_data == exp[b-1], tag, 512'(out_data), 512'(exp[b-1]));
      end
      beat_valid = 1'b1;
      beat_write = wr;
      beat_col   = {6'($urandom), slot};
      beat_data  = d[b];
      line_start = clr_last && (b == 7);
    end
    @(negedge clk);
    chk(out_valid, "R2", 512'(out_valid), 512'(1));
    chk(out_data == exp[7], tag, 512'(out_data), 512'(exp[7]));
    beat_valid = 1'b0;
    line_start = 1'b0;
    beat_col   = {6'($urandom), ~slot};
    if (clr_last) m_valid = '0;
    if (wr || !m_valid[slot]) begin
      m_line[slot]  = slice;
      m_valid[slot] = 1'b1;
    end
    check_mask(clr_last ? "R9" : tag);
  endtask

  task automatic new_line();
    @(negedge clk);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    m_valid = '0;
    check_mask("R9");
  endtask

  initial begin
    int cycles;
    cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        n_vec++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [3:0] perm [NSLOT];
    rst        = 1'b1;
    fault_dev  = '0;
    line_start = 1'b0;
    beat_valid = 1'b0;
    beat_write = 1'b0;
    beat_col   = '0;
    beat_data  = '0;
    m_valid    = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(slot_valid == '0, "R1", 512'(slot_valid), 512'(0));
    chk(!line_full, "R1", 512'(line_full), 512'(0));
    chk(!out_valid, "R1", 512'(out_valid), 512'(0));

    for (int dv = 0; dv <= NDEV; dv++) begin
      dev = dv;
      fault_dev = 5'(dv);
      new_line();
      for (int i = 0; i < NSLOT; i++) perm[i] = 4'(i);
      for (int i = NSLOT - 1; i > 0; i--) begin
        int j;
        logic [3:0] t;
        j = int'($urandom % (i + 1));
        t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
      for (int k = 0; k < NSLOT; k++) begin
        run_burst(perm[k], 1'b0, 1'b0);
        if (k < NSLOT - 1)
          chk(!line_full, "R8", 512'(line_full), 512'(0));
      end
      chk(line_full, "R8", 512'(line_full), 512'(1));
      check_line(dv >= NDEV ? "R3" : "R4");
      for (int k = 0; k < 3; k++) run_burst(4'($urandom), 1'b0, 1'b0);
      check_line("R6");
      run_burst(4'($urandom), 1'b1, 1'b0);
      check_line("R7");
      run_burst(4'($urandom), 1'b0, 1'b0);
      if (dv == 0) begin
        run_burst(4'd9, 1'b1, 1'b1);
        check_line("R9");
        chk(!line_full, "R9", 512'(line_full), 512'(0));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule